// File: doc/BRIEF.md
# Cache Line Maintenance Controller

This block keeps the bookkeeping state of a small set-associative cache. Each line has a tag, a valid bit, a dirty bit and a lock bit. It carries out maintenance commands on one line at a time. The target line is found in one of two ways: by tag lookup, where a miss usually means nothing happens, or by explicit set index and way number. The commands are invalidate, writeback, writeback-and-invalidate, prefetch-and-lock, unlock, sync and a whole-cache initialise. Line data, normal load/store traffic and replacement for ordinary misses belong to other blocks.

Writeback traffic leaves through a single memory request port, and so do line fills for prefetch-and-lock. That port carries the line address, a write/fill flag and a request/acknowledge pair. Only one command is active at a time. The command port's ready output stays low until every memory transfer of the current command has been acknowledged. Because of this, a sync command completes its handshake only after all earlier work is finished.

A mode parameter selects the flavour of cache:
- 0: a write-back data cache.
- 1: a write-through data cache.
- 2: an instruction cache.

A probe port lets the surrounding logic look up a line's state. The same probe port also marks a hitting line dirty, standing in for a store.

Top module: `cline_maint`

## Requirements
- R1: Invalidate (op 0) clears the valid bit of the target line unless it is locked; a locked line keeps valid and lock. A tag lookup that misses changes nothing.
- R2: In mode 0, writeback (op 1) of a valid dirty line issues one memory write (mem_we=1) at that line's address. The line then stays valid and becomes clean. On a clean line there is no memory traffic.
- R3: In mode 0, writeback-and-invalidate (op 2) first writes a dirty unlocked line back and then invalidates it. A clean unlocked line is invalidated with no memory traffic.
- R4: Writeback-and-invalidate on a locked dirty line writes it back and leaves it valid, locked and clean.
- R5: Prefetch-and-lock (op 3) always uses tag lookup:
  - On a hit it sets the lock bit with no traffic.
  - On a miss the victim is the lowest-numbered invalid way, or failing that the lowest-numbered unlocked way. In mode 0 a dirty victim is written back first. The line address is then fetched with a fill (mem_we=0), and the line becomes valid, clean and locked.
  - If every way of the set is locked, nothing happens.
- R6: Unlock (op 4) clears the lock bit of the target line; a line that is not locked stays as it was.
- R7: With cmd_by_index=1, the target of ops 0, 1, 2 and 4 is the set in the low IDX_W bits of cmd_addr and the way in cmd_way, whatever the tag.
- R8: Mode 2 ignores ops 1 and 2 entirely. In mode 1, op 1 does nothing and op 2 acts as a plain invalidate. Neither mode ever issues a memory write.
- R9: Initialise (op 6) holds the block busy for 2*SETS cycles. In that time it first clears every lock bit and then clears every valid and dirty bit.
- R10: cmd_ready is low while any command is in progress. A memory request holds its address and direction until acknowledged. Sync (op 5) has no effect on line state and is accepted only when the block is idle.
- R11: The probe reports hit, dirty and lock for probe_addr with no delay. A dirty_set pulse on a probe hit makes that line dirty at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; all lines invalid, clean, unlocked |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle; command accepted when both high |
| cmd_op | input | 3 | Operation code (see R1 to R10) |
| cmd_by_index | input | 1 | 1: target by set index and way; 0: by tag lookup |
| cmd_addr | input | LA_W | Line address: tag above, set index in low IDX_W bits |
| cmd_way | input | WAY_W | Way number for index mode |
| probe_addr | input | LA_W | Line address to look up |
| dirty_set | input | 1 | Mark the probed line dirty if it hits |
| probe_hit | output | 1 | probe_addr is present and valid |
| probe_dirty | output | 1 | Probed line is dirty |
| probe_lock | output | 1 | Probed line is locked |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | 1: writeback, 0: fill |
| mem_addr | output | LA_W | Line address of the request |
| mem_ack | input | 1 | Memory accepts the pending request |

## Verification
On every cycle, the assertions check the following:
- The command port stays closed while memory traffic is outstanding (R10).
- A pending request keeps its address and direction until acknowledged (R10).
- A fill ends the command (R5).
- An invalidate on a locked line leaves it present and locked (R1).
- An unlock leaves the line unlocked (R6).

Several properties can only be shown by the directed scenarios:
- Victim choice and the write-before-fill ordering (R5).
- The exact addresses and counts of writes and fills (R2, R3, R4).
- The mode-dependent behaviour, seen by running three differently configured copies side by side (R8).
- Index-mode targeting (R7).
- The length and result of the initialise walk (R9).

// File: rtl/cline_maint.sv
module cline_maint #(
  parameter int LA_W  = 12,
  parameter int IDX_W = 2,
  parameter int WAY_W = 1,
  parameter int MODE  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic             cmd_by_index,
  input  logic [LA_W-1:0]  cmd_addr,
  input  logic [WAY_W-1:0] cmd_way,
  input  logic [LA_W-1:0]  probe_addr,
  input  logic             dirty_set,
  output logic             probe_hit,
  output logic             probe_dirty,
  output logic             probe_lock,
  output logic             mem_req,
  output logic             mem_we,
  output logic [LA_W-1:0]  mem_addr,
  input  logic             mem_ack
);
  localparam int SETS  = 1 << IDX_W;
  localparam int WAYS  = 1 << WAY_W;
  localparam int LINES = SETS * WAYS;
  localparam int TAG_W = LA_W - IDX_W;
  localparam int LN_W  = IDX_W + WAY_W;
  localparam logic [2:0] OP_INV = 3'd0, OP_WB = 3'd1, OP_WBI = 3'd2,
                         OP_LOCK = 3'd3, OP_UNLOCK = 3'd4, OP_INIT = 3'd6;
  localparam bit WB_ON = (MODE == 0);

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL, S_INIT} state_t;
  state_t state;

  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] val_q, dty_q, lck_q;
  logic [LN_W-1:0]  r_line;
  logic [TAG_W-1:0] r_tag;
  logic [2:0]       r_op;
  logic [IDX_W:0]   cnt;

  wire [IDX_W-1:0] c_set = cmd_addr[IDX_W-1:0];
  wire [TAG_W-1:0] c_tag = cmd_addr[LA_W-1:IDX_W];
  wire [IDX_W-1:0] p_set = probe_addr[IDX_W-1:0];
  wire [TAG_W-1:0] p_tag = probe_addr[LA_W-1:IDX_W];

  logic c_hit, p_hit, v_ok, i_ok;
  logic [WAY_W-1:0] c_way, p_way, v_way, i_way;
  always_comb begin
    c_hit = 1'b0; c_way = '0; p_hit = 1'b0; p_way = '0;
    v_ok = 1'b0; v_way = '0; i_ok = 1'b0; i_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (val_q[{c_set, WAY_W'(w)}] && tag_q[{c_set, WAY_W'(w)}] == c_tag) begin
        c_hit = 1'b1; c_way = WAY_W'(w);
      end
      if (val_q[{p_set, WAY_W'(w)}] && tag_q[{p_set, WAY_W'(w)}] == p_tag) begin
        p_hit = 1'b1; p_way = WAY_W'(w);
      end
      if (!lck_q[{c_set, WAY_W'(w)}]) begin v_ok = 1'b1; v_way = WAY_W'(w); end
      if (!val_q[{c_set, WAY_W'(w)}]) begin i_ok = 1'b1; i_way = WAY_W'(w); end
    end
  end

  wire [LN_W-1:0] p_line = {p_set, p_way};
  wire [LN_W-1:0] t_line = {c_set, cmd_by_index ? cmd_way : c_way};
  wire            t_ok   = cmd_by_index | c_hit;
  wire [LN_W-1:0] v_line = {c_set, i_ok ? i_way : v_way};
  wire [IDX_W-1:0] r_set = r_line[LN_W-1:WAY_W];

  assign probe_hit   = p_hit;
  assign probe_dirty = p_hit & dty_q[p_line];
  assign probe_lock  = p_hit & lck_q[p_line];
  assign cmd_ready   = (state == S_IDLE);
  assign mem_req     = (state == S_WB) || (state == S_FILL);
  assign mem_we      = (state == S_WB);

  always_ff @(posedge clk) begin
    if (state == S_FILL && mem_ack) tag_q[r_line] <= r_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      val_q <= '0; dty_q <= '0; lck_q <= '0;
      r_line <= '0; r_tag <= '0; r_op <= '0; cnt <= '0; mem_addr <= '0;
    end else begin
      if (dirty_set && p_hit) dty_q[p_line] <= 1'b1;
      case (state)
        S_IDLE: if (cmd_valid) begin
          r_line <= t_line; r_tag <= c_tag; r_op <= cmd_op;
          case (cmd_op)
            OP_INV: if (t_ok && !lck_q[t_line]) val_q[t_line] <= 1'b0;
            OP_WB, OP_WBI: begin
              if (WB_ON && t_ok && val_q[t_line] && dty_q[t_line]) begin
                state <= S_WB;
                mem_addr <= {tag_q[t_line], c_set};
              end else if (cmd_op == OP_WBI && MODE != 2 && t_ok && !lck_q[t_line]) begin
                val_q[t_line] <= 1'b0; dty_q[t_line] <= 1'b0;
              end
            end
            OP_LOCK: begin
              if (c_hit) lck_q[{c_set, c_way}] <= 1'b1;
              else if (v_ok) begin
                r_line <= v_line;
                if (WB_ON && val_q[v_line] && dty_q[v_line]) begin
                  state <= S_WB;
                  mem_addr <= {tag_q[v_line], c_set};
                end else begin
                  state <= S_FILL;
                  val_q[v_line] <= 1'b0;
                  mem_addr <= cmd_addr;
                end
              end
            end
            OP_UNLOCK: if (t_ok) lck_q[t_line] <= 1'b0;
            OP_INIT: begin state <= S_INIT; cnt <= '0; end
            default: ;
          endcase
        end
        S_WB: if (mem_ack) begin
          dty_q[r_line] <= 1'b0;
          if (r_op == OP_LOCK) begin
            state <= S_FILL;
            val_q[r_line] <= 1'b0;
            mem_addr <= {r_tag, r_set};
          end else begin
            state <= S_IDLE;
            if (r_op == OP_WBI && !lck_q[r_line]) val_q[r_line] <= 1'b0;
          end
        end
        S_FILL: if (mem_ack) begin
          val_q[r_line] <= 1'b1; dty_q[r_line] <= 1'b0; lck_q[r_line] <= 1'b1;
          state <= S_IDLE;
        end
        S_INIT: begin
          for (int w = 0; w < WAYS; w++) begin
            if (!cnt[IDX_W]) lck_q[{cnt[IDX_W-1:0], WAY_W'(w)}] <= 1'b0;
            else begin
              val_q[{cnt[IDX_W-1:0], WAY_W'(w)}] <= 1'b0;
              dty_q[{cnt[IDX_W-1:0], WAY_W'(w)}] <= 1'b0;
            end
          end
          cnt <= cnt + 1'b1;
          if (&cnt) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cline_maint_chk.sv
module cline_maint_chk #(
  parameter int LA_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [2:0]      cmd_op,
  input logic            cmd_by_index,
  input logic [LA_W-1:0] cmd_addr,
  input logic [LA_W-1:0] probe_addr,
  input logic            probe_hit,
  input logic            probe_lock,
  input logic            mem_req,
  input logic            mem_we,
  input logic [LA_W-1:0] mem_addr,
  input logic            mem_ack
);
  wire take = cmd_valid && cmd_ready && !cmd_by_index && probe_addr == cmd_addr;

  // R10
  busy_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cmd_ready);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R5
  fill_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !mem_we |=> !mem_req && cmd_ready);

  // R1
  locked_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && cmd_op == 3'd0 && probe_lock |=> ($stable(probe_addr) -> (probe_hit && probe_lock)));

  // R6
  unlock_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && cmd_op == 3'd4 && probe_hit |=> ($stable(probe_addr) -> !probe_lock));
endmodule

bind cline_maint cline_maint_chk #(.LA_W(LA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_by_index(cmd_by_index), .cmd_addr(cmd_addr),
  .probe_addr(probe_addr), .probe_hit(probe_hit), .probe_lock(probe_lock),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack));

// File: tb/cline_maint_test.sv
`timescale 1ns/1ps
module cline_maint_test;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic cmd_valid = 0, cmd_by_index = 0, dirty_set = 0, hold = 0;
  logic [2:0] cmd_op = 0;
  logic [11:0] cmd_addr = 0, probe_addr = 0;
  logic [0:0] cmd_way = 0;
  logic rdy [3], req [3], we [3], ack [3], phit [3], pdty [3], plck [3];
  logic [11:0] maddr [3], last_w [3], last_f [3];
  int wcnt [3], fcnt [3];
  int checks = 0, fails = 0;

  cline_maint #(.MODE(0)) uut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy[0]),
    .cmd_op(cmd_op), .cmd_by_index(cmd_by_index), .cmd_addr(cmd_addr), .cmd_way(cmd_way),
    .probe_addr(probe_addr), .dirty_set(dirty_set), .probe_hit(phit[0]), .probe_dirty(pdty[0]),
    .probe_lock(plck[0]), .mem_req(req[0]), .mem_we(we[0]), .mem_addr(maddr[0]), .mem_ack(ack[0]));
  cline_maint #(.MODE(1)) uut_wt (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy[1]),
    .cmd_op(cmd_op), .cmd_by_index(cmd_by_index), .cmd_addr(cmd_addr), .cmd_way(cmd_way),
    .probe_addr(probe_addr), .dirty_set(dirty_set), .probe_hit(phit[1]), .probe_dirty(pdty[1]),
    .probe_lock(plck[1]), .mem_req(req[1]), .mem_we(we[1]), .mem_addr(maddr[1]), .mem_ack(ack[1]));
  cline_maint #(.MODE(2)) uut_ic (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy[2]),
    .cmd_op(cmd_op), .cmd_by_index(cmd_by_index), .cmd_addr(cmd_addr), .cmd_way(cmd_way),
    .probe_addr(probe_addr), .dirty_set(dirty_set), .probe_hit(phit[2]), .probe_dirty(pdty[2]),
    .probe_lock(plck[2]), .mem_req(req[2]), .mem_we(we[2]), .mem_addr(maddr[2]), .mem_ack(ack[2]));

  always @(posedge clk) begin
    for (int k = 0; k < 3; k++) begin
      if (!rst_n) begin
        ack[k] <= 0; wcnt[k] <= 0; fcnt[k] <= 0; last_w[k] <= 0; last_f[k] <= 0;
      end else begin
        ack[k] <= req[k] && !ack[k] && !hold;
        if (req[k] && ack[k]) begin
          if (we[k]) begin wcnt[k] <= wcnt[k] + 1; last_w[k] <= maddr[k]; end
          else begin fcnt[k] <= fcnt[k] + 1; last_f[k] <= maddr[k]; end
        end
      end
    end
  end

  function automatic logic [11:0] la(input int tag, input int set);
    return {tag[9:0], set[1:0]};
  endfunction

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic peek(input int k, input logic [11:0] a, output logic [2:0] s);
    probe_addr = a; #1;
    s = {phit[k], pdty[k], plck[k]};
  endtask

  task automatic expect_st(input int k, input logic [11:0] a, input logic [2:0] e, input string r);
    logic [2:0] s;
    peek(k, a, s);
    chk(s == e, r, s, e);
  endtask

  task automatic wait_idle();
    while (!(rdy[0] && rdy[1] && rdy[2])) @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] op, input logic idx, input logic [11:0] a, input logic w);
    @(negedge clk); wait_idle();
    cmd_op = op; cmd_by_index = idx; cmd_addr = a; cmd_way = w; cmd_valid = 1;
    @(negedge clk); cmd_valid = 0; cmd_by_index = 0;
    wait_idle();
  endtask

  task automatic mark(input logic [11:0] a);
    @(negedge clk); probe_addr = a; dirty_set = 1;
    @(negedge clk); dirty_set = 0;
  endtask

  task automatic load(input logic [11:0] a);
    issue(3'd3, 0, a, 0);
    issue(3'd4, 0, a, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(rdy[0] && !req[0], "R10 idle after reset", {rdy[0], req[0]}, 2'b10);
    expect_st(0, la(1, 0), 3'b000, "R11 empty after reset");
  endtask

  task automatic t_inv();
    load(la(1, 0));
    expect_st(0, la(1, 0), 3'b100, "R11 loaded line visible");
    issue(3'd0, 0, la(1, 0), 0);
    expect_st(0, la(1, 0), 3'b000, "R1 invalidate clears");
    issue(3'd3, 0, la(2, 1), 0);
    issue(3'd0, 0, la(2, 1), 0);
    expect_st(0, la(2, 1), 3'b101, "R1 locked line survives");
    load(la(4, 2));
    issue(3'd0, 0, la(5, 2), 0);
    expect_st(0, la(4, 2), 3'b100, "R1 miss has no effect");
  endtask

  task automatic t_wb();
    int w0;
    load(la(6, 3));
    mark(la(6, 3));
    expect_st(0, la(6, 3), 3'b110, "R11 dirty_set marks line");
    w0 = wcnt[0];
    issue(3'd1, 0, la(6, 3), 0);
    chk(wcnt[0] == w0 + 1, "R2 one write", wcnt[0], w0 + 1);
    chk(last_w[0] == la(6, 3), "R2 write address", last_w[0], la(6, 3));
    expect_st(0, la(6, 3), 3'b100, "R2 valid and clean");
    issue(3'd1, 0, la(6, 3), 0);
    chk(wcnt[0] == w0 + 1, "R2 clean line no write", wcnt[0], w0 + 1);
    expect_st(1, la(6, 3), 3'b110, "R8 write-through writeback ignored");
    expect_st(2, la(6, 3), 3'b110, "R8 icache writeback ignored");
    chk(wcnt[1] == 0 && wcnt[2] == 0, "R8 no writes in modes 1/2", wcnt[1] + wcnt[2], 0);
  endtask

  task automatic t_wbi();
    int w0;
    load(la(7, 0));
    mark(la(7, 0));
    w0 = wcnt[0];
    issue(3'd2, 0, la(7, 0), 0);
    chk(wcnt[0] == w0 + 1 && last_w[0] == la(7, 0), "R3 dirty written back", last_w[0], la(7, 0));
    expect_st(0, la(7, 0), 3'b000, "R3 then invalid");
    expect_st(1, la(7, 0), 3'b000, "R8 write-through acts as invalidate");
    expect_st(2, la(7, 0), 3'b110, "R8 icache ignores op 2");
    load(la(8, 1));
    w0 = wcnt[0];
    issue(3'd2, 0, la(8, 1), 0);
    chk(wcnt[0] == w0, "R3 clean line no write", wcnt[0], w0);
    expect_st(0, la(8, 1), 3'b000, "R3 clean line invalidated");
  endtask

  task automatic t_wbi_locked();
    int w0;
    mark(la(2, 1));
    w0 = wcnt[0];
    issue(3'd2, 0, la(2, 1), 0);
    chk(wcnt[0] == w0 + 1 && last_w[0] == la(2, 1), "R4 locked dirty written", last_w[0], la(2, 1));
    expect_st(0, la(2, 1), 3'b101, "R4 stays valid locked clean");
  endtask

  task automatic t_lock();
    int f0, w0;
    f0 = fcnt[0];
    issue(3'd3, 0, la(9, 2), 0);
    chk(fcnt[0] == f0 + 1 && last_f[0] == la(9, 2), "R5 miss fills", last_f[0], la(9, 2));
    expect_st(0, la(9, 2), 3'b101, "R5 filled and locked");
    issue(3'd3, 0, la(9, 2), 0);
    chk(fcnt[0] == f0 + 1, "R5 hit no fill", fcnt[0], f0 + 1);
    mark(la(4, 2));
    w0 = wcnt[0];
    issue(3'd3, 0, la(10, 2), 0);
    chk(wcnt[0] == w0 + 1 && last_w[0] == la(4, 2), "R5 dirty victim written", last_w[0], la(4, 2));
    chk(fcnt[0] == f0 + 2 && last_f[0] == la(10, 2), "R5 fill after writeback", last_f[0], la(10, 2));
    expect_st(0, la(4, 2), 3'b000, "R5 unlocked victim evicted");
    expect_st(0, la(9, 2), 3'b101, "R5 locked way kept");
    issue(3'd3, 0, la(11, 2), 0);
    chk(fcnt[0] == f0 + 2, "R5 all ways locked no fill", fcnt[0], f0 + 2);
    expect_st(0, la(11, 2), 3'b000, "R5 all ways locked no alloc");
  endtask

  task automatic t_unlock();
    issue(3'd4, 0, la(10, 2), 0);
    expect_st(0, la(10, 2), 3'b100, "R6 lock cleared");
    issue(3'd4, 0, la(10, 2), 0);
    expect_st(0, la(10, 2), 3'b100, "R6 unlocked line unchanged");
    expect_st(0, la(9, 2), 3'b101, "R6 other way untouched");
  endtask

  task automatic t_index();
    issue(3'd0, 1, la(0, 2), 0);
    expect_st(0, la(10, 2), 3'b000, "R7 index invalidate way 0");
    expect_st(0, la(9, 2), 3'b101, "R7 way 1 untouched");
    issue(3'd4, 1, la(0, 2), 1);
    expect_st(0, la(9, 2), 3'b100, "R7 index unlock way 1");
  endtask

  task automatic t_sync();
    logic got;
    mark(la(6, 3));
    @(negedge clk); wait_idle();
    hold = 1;
    cmd_op = 3'd1; cmd_addr = la(6, 3); cmd_valid = 1;
    @(negedge clk); cmd_op = 3'd5;
    for (int i = 0; i < 3; i++) begin
      chk(!rdy[0] && req[0] && we[0], "R10 sync held off", {rdy[0], req[0]}, 2'b01);
      chk(maddr[0] == la(6, 3), "R10 address stable", maddr[0], la(6, 3));
      @(negedge clk);
    end
    hold = 0;
    got = 0;
    for (int i = 0; i < 10 && !got; i++) begin
      if (rdy[0]) got = 1;
      @(negedge clk);
    end
    cmd_valid = 0;
    chk(got, "R10 sync accepted when idle", got, 1);
    expect_st(0, la(6, 3), 3'b100, "R10 earlier writeback done");
  endtask

  task automatic t_init();
    int n;
    @(negedge clk); wait_idle();
    cmd_op = 3'd6; cmd_valid = 1;
    @(negedge clk); cmd_valid = 0;
    n = 0;
    while (!rdy[0] && n < 50) begin n++; @(negedge clk); end
    chk(n == 8, "R9 busy 2*SETS cycles", n, 8);
    expect_st(0, la(9, 2), 3'b000, "R9 line cleared");
    expect_st(0, la(2, 1), 3'b000, "R9 locked line cleared");
    expect_st(2, la(7, 0), 3'b000, "R9 dirty line cleared");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_inv();
    t_wb();
    t_wbi();
    t_wbi_locked();
    t_lock();
    t_unlock();
    t_index();
    t_sync();
    t_init();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule